// File: doc/BRIEF.md
# Condition Field Group Legality Checker

This block screens decoded vector-extended instructions whose operands may name condition-register fields. There are 128 such fields. The block treats the low eight (the legacy group) and the remaining 120 (the extended group) as if they lived in two separate register files. When an instruction breaks the separation rules, the block flags it so that the pipeline raises an illegal-instruction trap instead of executing it.

Each instruction offers up to three source operands and one destination operand. Every operand carries a valid bit, a 7-bit field index, a bit saying whether it is a condition field, and a scalar/vector flag. The instruction also gives its source count and destination count.

The block applies one of two rules. A move (exactly one source and one destination) may cross groups, but it may not use a legacy field as a vector. Any other instruction may not mix the groups at all. The verdict is registered. It appears one cycle after the input, together with a 2-bit reason code.

Top module: `crgg_top`

## Requirements
- R1: A field index below 8 belongs to the legacy group, and an index of 8 or above belongs to the extended group. For a vector operand, the group is taken from its base index.
- R2: When the instruction is not a move (a move means source count 1 and destination count 1), and its active condition-field operands include both a legacy and an extended field, the result is trap=1 with reason 1.
- R3: For a move, any active condition-field operand in the legacy group that has its vector flag set gives trap=1 with reason 2.
- R4: For a move, a scalar legacy destination fed from an extended source is legal, and so is an extended scalar source splatted into an extended vector destination. Both give trap=0 with reason 0.
- R5: An operand whose valid bit is clear, or whose condition-field bit is clear, has no effect on the verdict.
- R6: An instruction with no active condition-field operand always gives trap=0 with reason 0.
- R7: in_ready is always 1. out_valid equals in_valid delayed by exactly one clock, and each accepted instruction yields exactly one result in order.
- R8: out_reason takes only the values 0 (none), 1 (groups mixed) and 2 (legacy vector). out_trap is 1 exactly when out_reason is nonzero. While out_valid is 0, both out_trap and out_reason are 0.
- R9: While reset is asserted and right after it is released, out_valid, out_trap and out_reason are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | Always 1 |
| src_cnt | input | 2 | Number of source operands |
| dst_cnt | input | 1 | Number of destination operands |
| op_valid | input | 4 | Operand present; bits 0 to 2 are sources, bit 3 is the destination |
| op_is_cr | input | 4 | Operand is a condition field |
| op_vec | input | 4 | Operand is a vector |
| op_idx | input | 28 | Field indices, 7 bits per operand, operand k at bits [7k+6:7k] |
| out_valid | output | 1 | A verdict is present |
| out_trap | output | 1 | Illegal-instruction trap request |
| out_reason | output | 2 | 0 none, 1 groups mixed, 2 legacy vector |

## Verification
A wrong group decision or a wrong rule selection shows up on out_trap and out_reason in the very cycle after the offending instruction. The stimulus therefore sits on the 7/8 index boundary and uses both move and non-move counts. A stale verdict register would leave a trap or reason visible during idle cycles, and those idle cycles are checked. A broken valid pipeline shows as a missing or extra result against the in-order queue of expected verdicts.

// File: rtl/crgg_pkg.sv
package crgg_pkg;
  typedef enum logic [1:0] {
    RSN_NONE   = 2'd0,
    RSN_MIX    = 2'd1,
    RSN_LEGVEC = 2'd2
  } reason_e;

  typedef struct packed {
    logic    trap;
    reason_e reason;
  } verdict_t;
endpackage

// File: rtl/crgg_rst_sync.sv
module crgg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/crgg_classify.sv
module crgg_classify #(
  parameter int NUM_OPS  = 4,
  parameter int IDX_W    = 7,
  parameter int LEGACY_N = 8
) (
  input  logic [NUM_OPS-1:0]       op_valid,
  input  logic [NUM_OPS-1:0]       op_is_cr,
  input  logic [NUM_OPS-1:0]       op_vec,
  input  logic [NUM_OPS*IDX_W-1:0] op_idx,
  output logic [NUM_OPS-1:0]       leg_hit,
  output logic [NUM_OPS-1:0]       ext_hit,
  output logic [NUM_OPS-1:0]       legvec_hit
);
  localparam logic [IDX_W-1:0] LEG_LIMIT = IDX_W'(LEGACY_N);

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    logic active;
    logic in_legacy;
    always_comb begin
      active        = op_valid[k] & op_is_cr[k];
      in_legacy     = op_idx[k*IDX_W +: IDX_W] < LEG_LIMIT;
      leg_hit[k]    = active & in_legacy;
      ext_hit[k]    = active & ~in_legacy;
      legvec_hit[k] = active & in_legacy & op_vec[k];
    end
  end
endmodule

// File: rtl/crgg_rule.sv
module crgg_rule
  import crgg_pkg::*;
#(
  parameter int NUM_OPS = 4,
  parameter int CNT_W   = 2
) (
  input  logic [CNT_W-1:0]   src_cnt,
  input  logic               dst_cnt,
  input  logic [NUM_OPS-1:0] leg_hit,
  input  logic [NUM_OPS-1:0] ext_hit,
  input  logic [NUM_OPS-1:0] legvec_hit,
  output verdict_t           verdict
);
  logic is_move;
  logic mixed;
  logic legvec;

  always_comb begin
    is_move = (src_cnt == CNT_W'(1)) && dst_cnt;
    mixed   = (|leg_hit) && (|ext_hit);
    legvec  = |legvec_hit;
    verdict = '{trap: 1'b0, reason: RSN_NONE};
    if (is_move) begin
      if (legvec) verdict = '{trap: 1'b1, reason: RSN_LEGVEC};
    end else begin
      if (mixed)  verdict = '{trap: 1'b1, reason: RSN_MIX};
    end
  end
endmodule

// File: rtl/crgg_top.sv
module crgg_top
  import crgg_pkg::*;
#(
  parameter int NUM_SRC  = 3,
  parameter int IDX_W    = 7,
  parameter int LEGACY_N = 8,
  parameter int SYNC_N   = 2,
  localparam int NUM_OPS = NUM_SRC + 1,
  localparam int CNT_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [CNT_W-1:0]         src_cnt,
  input  logic                     dst_cnt,
  input  logic [NUM_OPS-1:0]       op_valid,
  input  logic [NUM_OPS-1:0]       op_is_cr,
  input  logic [NUM_OPS-1:0]       op_vec,
  input  logic [NUM_OPS*IDX_W-1:0] op_idx,
  output logic                     out_valid,
  output logic                     out_trap,
  output logic [1:0]               out_reason
);
  logic                rst_sync_n;
  logic [NUM_OPS-1:0]  leg_hit, ext_hit, legvec_hit;
  verdict_t            verdict;
  verdict_t            res_d, res_q;
  logic                vld_d, vld_q;

  crgg_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  crgg_classify #(.NUM_OPS(NUM_OPS), .IDX_W(IDX_W), .LEGACY_N(LEGACY_N)) u_cls (
    .op_valid   (op_valid),
    .op_is_cr   (op_is_cr),
    .op_vec     (op_vec),
    .op_idx     (op_idx),
    .leg_hit    (leg_hit),
    .ext_hit    (ext_hit),
    .legvec_hit (legvec_hit)
  );

  crgg_rule #(.NUM_OPS(NUM_OPS), .CNT_W(CNT_W)) u_rule (
    .src_cnt    (src_cnt),
    .dst_cnt    (dst_cnt),
    .leg_hit    (leg_hit),
    .ext_hit    (ext_hit),
    .legvec_hit (legvec_hit),
    .verdict    (verdict)
  );

  assign in_ready = 1'b1;

  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? verdict : '{trap: 1'b0, reason: RSN_NONE};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '{trap: 1'b0, reason: RSN_NONE};
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_trap   = res_q.trap;
  assign out_reason = res_q.reason;
endmodule

// File: rtl/crgg_checker.sv
module crgg_checker #(
  parameter int NUM_OPS = 4
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               in_valid,
  input logic [NUM_OPS-1:0] op_valid,
  input logic [NUM_OPS-1:0] op_is_cr,
  input logic               out_valid,
  input logic               out_trap,
  input logic [1:0]         out_reason
);
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_idle_follows_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  p_trap_matches_reason_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_trap == (out_reason != 2'd0));
  p_idle_clean_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> (!out_trap && out_reason == 2'd0));
  p_reason_range_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_reason != 2'd3);
  p_no_cr_passes_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && ((op_valid & op_is_cr) == '0)) |=> !out_trap);
endmodule

bind crgg_top crgg_checker #(.NUM_OPS(NUM_OPS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .op_valid   (op_valid),
  .op_is_cr   (op_is_cr),
  .out_valid  (out_valid),
  .out_trap   (out_trap),
  .out_reason (out_reason)
);

// File: tb/crgg_top_test.sv
module crgg_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  src_cnt;
  logic        dst_cnt;
  logic [3:0]  op_valid, op_is_cr, op_vec;
  logic [27:0] op_idx;
  logic        out_valid, out_trap;
  logic [1:0]  out_reason;

  int total = 0;
  int bad   = 0;
  logic [2:0] expq[$];
  string      tagq[$];
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  crgg_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_cnt(src_cnt), .dst_cnt(dst_cnt), .op_valid(op_valid),
    .op_is_cr(op_is_cr), .op_vec(op_vec), .op_idx(op_idx),
    .out_valid(out_valid), .out_trap(out_trap), .out_reason(out_reason)
  );

  function automatic logic [2:0] model(input logic [1:0] sc, input logic dc,
                                       input logic [3:0] v, input logic [3:0] c,
                                       input logic [3:0] vec, input logic [27:0] ix);
    bit leg = 0, ext = 0, lv = 0;
    for (int k = 0; k < 4; k++) begin
      if (v[k] && c[k]) begin
        if (ix[k*7 +: 7] <= 7'd7) begin
          leg = 1;
          if (vec[k]) lv = 1;
        end else ext = 1;
      end
    end
    if (sc == 2'd1 && dc) return lv ? 3'b110 : 3'b000;
    return (leg && ext) ? 3'b101 : 3'b000;
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: trap/reason actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [1:0] sc, input logic dc,
                      input logic [3:0] v, input logic [3:0] c, input logic [3:0] vec,
                      input logic [6:0] i0, input logic [6:0] i1,
                      input logic [6:0] i2, input logic [6:0] i3);
    @(negedge clk);
    in_valid = 1'b1; src_cnt = sc; dst_cnt = dc;
    op_valid = v; op_is_cr = c; op_vec = vec; op_idx = {i3, i2, i1, i0};
    expq.push_back(model(sc, dc, v, c, vec, {i3, i2, i1, i0}));
    tagq.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: a result registered at a posedge is sampled shortly after it.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (expq.size() == 0) begin
          total++; bad++;
          $display("FAIL R7: unexpected result actual=1 expected=0");
        end else begin
          logic [2:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(t, {out_trap, out_reason}, e);
        end
      end else if (out_trap || out_reason != 2'd0) begin
        total++; bad++;
        $display("FAIL R8: idle outputs actual=%b expected=000", {out_trap, out_reason});
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000 && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; in_valid = 1'b0; src_cnt = '0; dst_cnt = 1'b0;
    op_valid = '0; op_is_cr = '0; op_vec = '0; op_idx = '0;
    repeat (3) @(negedge clk);
    check("R9 reset", {out_valid, out_trap, out_reason}, 3'b000);
    total++;
    if (in_ready !== 1'b1) begin bad++; $display("FAIL R7: in_ready actual=%b expected=1", in_ready); end
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", {out_valid, out_trap, out_reason}, 3'b000);
    repeat (3) @(negedge clk);

    // R2: dst 7 with sources 9,10 crosses groups
    send("R2 cross 7<-9,10", 2'd2, 1'b1, 4'b1011, 4'b1011, 4'b0000, 7'd9, 7'd10, 7'd0, 7'd7);
    // R4: scalar legacy dst 5 from extended 40
    send("R4 copy 40->5", 2'd1, 1'b1, 4'b1001, 4'b1001, 4'b0000, 7'd40, 7'd0, 7'd0, 7'd5);
    // R4: splat 40 into vector 16
    send("R4 splat 40->*16", 2'd1, 1'b1, 4'b1001, 4'b1001, 4'b1000, 7'd40, 7'd0, 7'd0, 7'd16);
    // R3: splat 40 into vector 0
    send("R3 splat 40->*0", 2'd1, 1'b1, 4'b1001, 4'b1001, 4'b1000, 7'd40, 7'd0, 7'd0, 7'd0);
    // R3: vector legacy source in a move
    send("R3 vec src 3", 2'd1, 1'b1, 4'b1001, 4'b1001, 4'b0001, 7'd3, 7'd0, 7'd0, 7'd50);
    // R2: all extended vectors legal
    send("R2 all ext", 2'd2, 1'b1, 4'b1011, 4'b1011, 4'b1011, 7'd16, 7'd40, 7'd0, 7'd8);
    // R1: boundary 7 vs 8 mixes
    send("R1 boundary 7/8", 2'd2, 1'b1, 4'b1011, 4'b1011, 4'b0000, 7'd7, 7'd7, 7'd0, 7'd8);
    // R1: boundary all legacy with 7 and 0 is legal
    send("R1 all legacy", 2'd3, 1'b1, 4'b1111, 4'b1111, 4'b0000, 7'd0, 7'd7, 7'd3, 7'd6);
    // R5: invalid legacy operand ignored
    send("R5 valid clear", 2'd2, 1'b1, 4'b1010, 4'b1011, 4'b0000, 7'd7, 7'd9, 7'd0, 7'd10);
    // R5: non-condition legacy operand ignored
    send("R5 is_cr clear", 2'd2, 1'b1, 4'b1011, 4'b1010, 4'b0000, 7'd2, 7'd9, 7'd0, 7'd10);
    // R5: legacy vector flag on non-condition operand in a move
    send("R5 move vec not cr", 2'd1, 1'b1, 4'b1001, 4'b1000, 4'b0001, 7'd1, 7'd0, 7'd0, 7'd5);
    // R6: no condition operands
    send("R6 no cr", 2'd3, 1'b1, 4'b1111, 4'b0000, 4'b1111, 7'd1, 7'd90, 7'd4, 7'd20);
    // R2: legacy vector in non-move is not a violation of the move rule
    send("R2 legacy vec multi", 2'd2, 1'b1, 4'b1011, 4'b1011, 4'b1011, 7'd0, 7'd2, 7'd0, 7'd4);
    idle(); idle(); idle();
    // R7/R8: gap then burst of mixed patterns
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      logic [27:0] ix;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ix = {lfsr[3] ? 7'(lfsr[6:4]) : 7'(lfsr[10:4] | 7'd8),
            7'(lfsr[8:2]), lfsr[1] ? 7'(lfsr[2:0]) : 7'd64, 7'(lfsr[15:9] >> lfsr[0])};
      if (lfsr[14] && n[0]) idle();
      send("R7 burst", lfsr[1:0], lfsr[2], lfsr[7:4], lfsr[11:8] | 4'b1000, lfsr[15:12],
           ix[6:0], ix[13:7], ix[20:14], ix[27:21]);
    end
    idle();
    repeat (4) @(negedge clk);
    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL R7: missing results actual=%0d expected=0", expq.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule